// File: doc/BRIEF.md
# I2C Bit-Level Clock and Data Timer

This block turns single-bit requests from an I2C byte engine into SCL and SDA open-drain drive enables. The byte engine issues one command at a time: a START (or repeated START), a STOP, or one data bit. The timer then walks the bus lines through the programmed timing. Every count is measured in cycles of the block clock. There are two pairs of high and low counts, one for standard speed and one for fast speed, and a mode input selects the active pair. Each programmed count passes through a fixed offset and a floor before use.

Each data bit follows the same order. SCL is already held low. SDA keeps its old level for a programmable hold time. SDA then moves to the new level, and SCL stays low for the low count and then for the setup time. SCL is then released, and the high count runs only while SCL is actually seen high, so a target that stretches the clock lengthens the high phase. At the end of the high phase SDA is sampled, SCL is pulled low again, and a one-cycle done strobe marks the end of the command. Between commands the block parks with SCL held low.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, SCL and SDA are both released (`scl_oe`=0, `sda_oe`=0), `ready`=1 and `step_done`=0.
- R2: The SCL high phase of a data bit lasts max(H,6)+8 cycles, where H is the high count of the active pair, provided no clock stretching occurs.
- R3: During a data bit, SCL stays low for max(L,8)+1 cycles after SDA takes its new level. L is the low count of the active pair.
- R4: `fast_mode`=1 selects the fast high/low pair, and `fast_mode`=0 selects the standard pair.
- R5: When `hold_cfg[8]`=1, SDA keeps its previous level for `hold_cfg[7:0]`+1 cycles after SCL is pulled low at the start of a bit. When `hold_cfg[8]`=0 there is no such delay. SDA never changes in the cycle in which SCL is pulled low.
- R6: After the low count, SCL stays low for a further max(S,1)-1 cycles (S = `setup_cfg`) before it is released. SDA does not change during the high phase of a data bit.
- R7: While SCL is released but `scl_in` reads low, the high-phase count pauses. Every cycle with `scl_in` low extends that phase by one cycle.
- R8: Command code 2'b00 is START. From idle, SDA is pulled low while SCL is high for max(H,6)+8 cycles, and then SCL is pulled low. From the parked state, the timer first clocks one bit with SDA released and then performs the same START sequence.
- R9: Command code 2'b01 is STOP and is valid only in the parked state. The timer clocks one bit with SDA held low. SCL then stays high with SDA low for max(S,1)-1 cycles. After that both lines are released and the block returns to idle. When idle and ready, SDA is never pulled low.
- R10: `step_done` is high for exactly one cycle, in the first cycle in which `ready` returns after a command. For a data bit, `rx_bit` then equals `sda_in` as seen in the last high cycle.
- R11: Command code 2'b10 is a data bit: `cmd_bit`=1 releases SDA and `cmd_bit`=0 pulls it low. Three kinds of command are ignored and leave every output unchanged: a data bit or STOP while idle, and code 2'b11 in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_mode | input | 1 | 1 selects the fast count pair |
| std_hi | input | CNT_W | Standard-speed high count |
| std_lo | input | CNT_W | Standard-speed low count |
| fast_hi | input | CNT_W | Fast-speed high count |
| fast_lo | input | CNT_W | Fast-speed low count |
| hold_cfg | input | HOLD_W+1 | SDA hold value in the low bits, and the hold enable in the top bit |
| setup_cfg | input | SU_W | Data setup value |
| cmd_valid | input | 1 | Command present; taken when `ready` is high |
| cmd_code | input | 2 | 00 START, 01 STOP, 10 data bit, 11 reserved |
| cmd_bit | input | 1 | Bit value for a data-bit command |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ready | output | 1 | Idle or parked, able to take a command |
| step_done | output | 1 | One-cycle command completion strobe |
| rx_bit | output | 1 | SDA sampled at the end of the last high phase |

## Verification
The bench uses the default parameters: CNT_W=16, HOLD_W=8 and SU_W=8. Small programmed counts (2 and 3) exercise the high and low floors, and larger ones (10, 20) exercise the plain offsets. A hold value of 255 gives the longest hold phase, 256 cycles. Setup values of 0 and 1 make the setup phase vanish, and a disabled hold with a non-zero value shows that the enable bit alone decides whether a hold phase occurs.

// File: rtl/i2c_bit_timer_pkg.sv
// Package: shared command codes and phase encodings for the bit timer.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_bit_timer_pkg;

    // Command codes from the byte engine; the values are part of the interface.
    typedef enum logic [1:0] {
        CMD_START = 2'b00,
        CMD_STOP  = 2'b01,
        CMD_BIT   = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PARK,
        PH_HOLD,
        PH_LOW,
        PH_SETUP,
        PH_HIGH,
        PH_START,
        PH_STOPSU
    } phase_e;

    // What follows the clock pulse of the bit path.
    typedef enum logic [1:0] {
        OP_BIT,
        OP_RSTART,
        OP_STOP
    } op_e;

    // Phases in which SCL is released and counting must wait for SCL high.
    function automatic logic scl_released_count(phase_e p);
        return (p == PH_HIGH) || (p == PH_START) || (p == PH_STOPSU);
    endfunction

endpackage

// File: rtl/i2c_bit_timer_cfg.sv
// Module: turns the programmed counts into effective phase lengths in cycles.
// It applies the floors and offsets, picks the active speed pair, and gates
// the hold delay with its enable bit.
// Assumes: the configuration is held stable while a command is in progress.
module i2c_bit_timer_cfg #(
    parameter int CNT_W    = 16,
    parameter int HOLD_W   = 8,
    parameter int SU_W     = 8,
    parameter int HI_FLOOR = 6,
    parameter int HI_OFS   = 8,
    parameter int LO_FLOOR = 8,
    parameter int LO_OFS   = 1
) (
    input  logic              fast_mode,
    input  logic [CNT_W-1:0]  std_hi,
    input  logic [CNT_W-1:0]  std_lo,
    input  logic [CNT_W-1:0]  fast_hi,
    input  logic [CNT_W-1:0]  fast_lo,
    input  logic [HOLD_W:0]   hold_cfg,
    input  logic [SU_W-1:0]   setup_cfg,
    output logic [CNT_W:0]    hi_len,
    output logic [CNT_W:0]    lo_len,
    output logic [HOLD_W:0]   hold_len,
    output logic [SU_W-1:0]   su_len
);
    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] raw_hi [2];
    logic [CNT_W-1:0] raw_lo [2];
    logic [LEN_W-1:0] eff_hi [2];
    logic [LEN_W-1:0] eff_lo [2];

    assign raw_hi[0] = std_hi;
    assign raw_hi[1] = fast_hi;
    assign raw_lo[0] = std_lo;
    assign raw_lo[1] = fast_lo;

    // One clamp-and-offset stage for each speed pair.
    for (genvar m = 0; m < 2; m++) begin : g_pair
        assign eff_hi[m] = ((raw_hi[m] < CNT_W'(HI_FLOOR)) ? LEN_W'(HI_FLOOR)
                                                          : {1'b0, raw_hi[m]})
                           + LEN_W'(HI_OFS);
        assign eff_lo[m] = ((raw_lo[m] < CNT_W'(LO_FLOOR)) ? LEN_W'(LO_FLOOR)
                                                          : {1'b0, raw_lo[m]})
                           + LEN_W'(LO_OFS);
    end

    // Select the active pair.
    assign hi_len = eff_hi[fast_mode];
    assign lo_len = eff_lo[fast_mode];

    // The hold lasts value+1 cycles when enabled and does not occur otherwise.
    assign hold_len = hold_cfg[HOLD_W] ? ({1'b0, hold_cfg[HOLD_W-1:0]} + (HOLD_W+1)'(1))
                                       : '0;

    // The setup lasts max(value,1)-1 cycles.
    assign su_len = (setup_cfg <= SU_W'(1)) ? '0 : setup_cfg - SU_W'(1);

endmodule

// File: rtl/i2c_bit_timer_cnt.sv
// Module: phase down-counter. It loads a length minus one on phase entry and
// steps down when allowed, and the sequencer ends the phase at zero.
// Assumes: a load and a step never need to take effect in the same cycle.
module i2c_bit_timer_cnt #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step_en,
    output logic [W-1:0] cnt_q,
    output logic         cnt_zero
);
    // Count register: a load takes priority over a step, and the count halts at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load)                    cnt_q <= load_val;
        else if (step_en && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/i2c_bit_timer_seq.sv
// Module: phase sequencer. It accepts commands, runs the bit path
// (hold, low, setup, high) and the START/STOP tails, and drives the line
// enables, the done strobe and the sampled bit.
// Assumes: scl_in and sda_in are already synchronised to clk, and all
// lengths come in zero-extended to CW bits.
module i2c_bit_timer_seq
    import i2c_bit_timer_pkg::*;
#(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] hi_len,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] hold_len,
    input  logic [CW-1:0] su_len,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    input  logic          cmd_bit,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          ready,
    output logic          step_done,
    output logic          rx_bit
);
    phase_e        st, st_n;
    op_e           op, op_n;
    logic          tgt, tgt_n;
    logic          sda_drv, sda_n;
    logic          done_q, done_n;
    logic          rx_q, rx_n;
    logic          load;
    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt_q;
    logic          cnt_zero;
    logic          step_en;
    logic          finish;
    logic          t;

    // A phase with SCL released counts only while the line is seen high.
    assign step_en = !scl_released_count(st) || scl_in;
    assign finish  = cnt_zero && step_en;

    i2c_bit_timer_cnt #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .step_en  (step_en),
        .cnt_q    (cnt_q),
        .cnt_zero (cnt_zero)
    );

    // Next-phase, line and strobe decisions.
    always_comb begin
        st_n     = st;
        op_n     = op;
        tgt_n    = tgt;
        sda_n    = sda_drv;
        done_n   = 1'b0;
        rx_n     = rx_q;
        load     = 1'b0;
        load_val = '0;
        t        = 1'b0;
        unique case (st)
            PH_IDLE: begin
                if (cmd_valid && cmd_code == CMD_START) begin
                    st_n     = PH_START;
                    sda_n    = 1'b1;
                    load     = 1'b1;
                    load_val = hi_len - CW'(1);
                end
            end
            PH_PARK: begin
                if (cmd_valid && cmd_code != CMD_RSVD) begin
                    unique case (cmd_code)
                        CMD_START: begin op_n = OP_RSTART; t = 1'b0;     end
                        CMD_STOP:  begin op_n = OP_STOP;   t = 1'b1;     end
                        default:   begin op_n = OP_BIT;    t = !cmd_bit; end
                    endcase
                    tgt_n = t;
                    load  = 1'b1;
                    if (hold_len != '0) begin
                        st_n     = PH_HOLD;
                        load_val = hold_len - CW'(1);
                    end else begin
                        st_n     = PH_LOW;
                        sda_n    = t;
                        load_val = lo_len - CW'(1);
                    end
                end
            end
            PH_HOLD: begin
                if (finish) begin
                    st_n     = PH_LOW;
                    sda_n    = tgt;
                    load     = 1'b1;
                    load_val = lo_len - CW'(1);
                end
            end
            PH_LOW: begin
                if (finish) begin
                    load = 1'b1;
                    if (su_len != '0) begin
                        st_n     = PH_SETUP;
                        load_val = su_len - CW'(1);
                    end else begin
                        st_n     = PH_HIGH;
                        load_val = hi_len - CW'(1);
                    end
                end
            end
            PH_SETUP: begin
                if (finish) begin
                    st_n     = PH_HIGH;
                    load     = 1'b1;
                    load_val = hi_len - CW'(1);
                end
            end
            PH_HIGH: begin
                if (finish) begin
                    rx_n = sda_in;
                    unique case (op)
                        OP_RSTART: begin
                            st_n     = PH_START;
                            sda_n    = 1'b1;
                            load     = 1'b1;
                            load_val = hi_len - CW'(1);
                        end
                        OP_STOP: begin
                            if (su_len != '0) begin
                                st_n     = PH_STOPSU;
                                load     = 1'b1;
                                load_val = su_len - CW'(1);
                            end else begin
                                st_n   = PH_IDLE;
                                sda_n  = 1'b0;
                                done_n = 1'b1;
                            end
                        end
                        default: begin
                            st_n   = PH_PARK;
                            done_n = 1'b1;
                        end
                    endcase
                end
            end
            PH_START: begin
                if (finish) begin
                    st_n   = PH_PARK;
                    done_n = 1'b1;
                end
            end
            PH_STOPSU: begin
                if (finish) begin
                    st_n   = PH_IDLE;
                    sda_n  = 1'b0;
                    done_n = 1'b1;
                end
            end
            default: st_n = PH_IDLE;
        endcase
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            op      <= OP_BIT;
            tgt     <= 1'b0;
            sda_drv <= 1'b0;
            done_q  <= 1'b0;
            rx_q    <= 1'b0;
        end else begin
            st      <= st_n;
            op      <= op_n;
            tgt     <= tgt_n;
            sda_drv <= sda_n;
            done_q  <= done_n;
            rx_q    <= rx_n;
        end
    end

    assign scl_oe    = !((st == PH_IDLE) || scl_released_count(st));
    assign sda_oe    = sda_drv;
    assign ready     = (st == PH_IDLE) || (st == PH_PARK);
    assign step_done = done_q;
    assign rx_bit    = rx_q;

    // The done strobe never lasts two cycles.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    // Idle with both lines released: SDA is not pulled low.
    assert_idle_sda_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !scl_oe) |-> !sda_oe);

    // SDA does not move in the cycle SCL is pulled low.
    assert_no_sda_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $stable(sda_oe));

    // A stretched SCL freezes the high count.
    assert_stretch_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_HIGH && !scl_in) |=> $stable(cnt_q));

    // Data stays put across the high phase of a bit.
    assert_data_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_HIGH && $past(st) == PH_HIGH) |-> $stable(sda_oe));

endmodule

// File: rtl/i2c_bit_timer.sv
// Module: top of the I2C bit timer. It joins the timing configuration and
// the phase sequencer, and sizes the shared counter to fit the longest phase.
// Assumes: synchronised bus inputs, a stable configuration during a command,
// and CNT_W >= HOLD_W.
module i2c_bit_timer #(
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 8,
    parameter int SU_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic [CNT_W-1:0]  std_hi,
    input  logic [CNT_W-1:0]  std_lo,
    input  logic [CNT_W-1:0]  fast_hi,
    input  logic [CNT_W-1:0]  fast_lo,
    input  logic [HOLD_W:0]   hold_cfg,
    input  logic [SU_W-1:0]   setup_cfg,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    input  logic              cmd_bit,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              ready,
    output logic              step_done,
    output logic              rx_bit
);
    localparam int LEN_W = CNT_W + 1;
    localparam int MAX_A = (LEN_W > HOLD_W + 1) ? LEN_W : HOLD_W + 1;
    localparam int CW    = (MAX_A > SU_W) ? MAX_A : SU_W;

    logic [CNT_W:0]  hi_len;
    logic [CNT_W:0]  lo_len;
    logic [HOLD_W:0] hold_len;
    logic [SU_W-1:0] su_len;

    i2c_bit_timer_cfg #(
        .CNT_W  (CNT_W),
        .HOLD_W (HOLD_W),
        .SU_W   (SU_W)
    ) u_cfg (
        .fast_mode (fast_mode),
        .std_hi    (std_hi),
        .std_lo    (std_lo),
        .fast_hi   (fast_hi),
        .fast_lo   (fast_lo),
        .hold_cfg  (hold_cfg),
        .setup_cfg (setup_cfg),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .hold_len  (hold_len),
        .su_len    (su_len)
    );

    i2c_bit_timer_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_len    (CW'(hi_len)),
        .lo_len    (CW'(lo_len)),
        .hold_len  (CW'(hold_len)),
        .su_len    (CW'(su_len)),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_bit   (cmd_bit),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .ready     (ready),
        .step_done (step_done),
        .rx_bit    (rx_bit)
    );

endmodule

// File: tb/i2c_bit_timer_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural model expands each command into a queue of expected
// per-cycle line states, and every cycle is compared at the falling clock edge.
module i2c_bit_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_mode = 1'b0;
    logic [15:0] std_hi = 16'd2, std_lo = 16'd3, fast_hi = 16'd20, fast_lo = 16'd10;
    logic [8:0]  hold_cfg = {1'b1, 8'd2};
    logic [7:0]  setup_cfg = 8'd4;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_code = 2'b00;
    logic        cmd_bit = 1'b0;
    logic        hold_low = 1'b0;
    logic        slave_low = 1'b0;
    logic        scl_in, sda_in;
    logic        scl_oe, sda_oe, ready, step_done, rx_bit;

    always #4 clk = ~clk;

    assign scl_in = !scl_oe && !hold_low;
    assign sda_in = !(sda_oe || slave_low);

    i2c_bit_timer u_i2c_bit_timer (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
        .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
        .hold_cfg(hold_cfg), .setup_cfg(setup_cfg),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bit(cmd_bit),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready),
        .step_done(step_done), .rx_bit(rx_bit)
    );

    typedef struct {
        logic  scl;
        logic  sda;
        logic  done;
        logic  rdy;
        logic  chk_rx;
        logic  rx;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    m_park = 0;
    logic  m_sda = 1'b0;
    string steady_tag = "R1";
    string hitag = "R2";
    string lotag = "R3";

    function automatic int hi_eff();
        int p = fast_mode ? int'(fast_hi) : int'(std_hi);
        return (p < 6 ? 6 : p) + 8;
    endfunction
    function automatic int lo_eff();
        int p = fast_mode ? int'(fast_lo) : int'(std_lo);
        return (p < 8 ? 8 : p) + 1;
    endfunction
    function automatic int hold_eff();
        return hold_cfg[8] ? int'(hold_cfg[7:0]) + 1 : 0;
    endfunction
    function automatic int su_eff();
        return (setup_cfg < 8'd1) ? 0 : int'(setup_cfg) - 1;
    endfunction

    task automatic push_n(input int n, input logic s, input logic d, input string tg);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.scl = s; e.sda = d; e.done = 1'b0; e.rdy = 1'b0;
            e.chk_rx = 1'b0; e.rx = 1'b0; e.tag = tg;
            exp_q.push_back(e);
        end
    endtask

    task automatic push_done(input logic s, input logic d, input logic crx, input logic rx);
        exp_t e;
        e.scl = s; e.sda = d; e.done = 1'b1; e.rdy = 1'b1;
        e.chk_rx = crx; e.rx = rx; e.tag = "R10";
        exp_q.push_back(e);
    endtask

    // The hold, low, setup and high phases of one clock pulse carrying level t.
    task automatic push_bitpath(input logic t, input int k);
        push_n(hold_eff(), 1'b1, m_sda, "R5");
        push_n(lo_eff(), 1'b1, t, lotag);
        push_n(su_eff(), 1'b1, t, "R6");
        push_n(hi_eff() + k, 1'b0, t, (k > 0) ? "R7" : hitag);
    endtask

    // Issue one command and queue its expected waveform. k = stretch cycles.
    task automatic issue(input logic [1:0] code, input logic b, input int k, input logic slv);
        int c;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_bit = b;
        slave_low = slv; hold_low = (k > 0);
        @(posedge clk);
        if (!m_park) begin
            if (code == 2'b00) begin
                push_n(hi_eff(), 1'b0, 1'b1, "R8");
                push_done(1'b1, 1'b1, 1'b0, 1'b0);
                m_park = 1; m_sda = 1'b1;
            end
        end else begin
            case (code)
                2'b00: begin
                    push_bitpath(1'b0, 0);
                    push_n(hi_eff(), 1'b0, 1'b1, "R8");
                    push_done(1'b1, 1'b1, 1'b0, 1'b0);
                    m_sda = 1'b1;
                end
                2'b01: begin
                    push_bitpath(1'b1, 0);
                    push_n(su_eff(), 1'b0, 1'b1, "R9");
                    push_done(1'b0, 1'b0, 1'b0, 1'b0);
                    m_park = 0; m_sda = 1'b0;
                end
                2'b10: begin
                    push_bitpath(!b, k);
                    push_done(1'b1, !b, 1'b1, !((!b) | slv));
                    m_sda = !b;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (k > 0) begin
            c = 0;
            while (1) begin
                if (scl_oe == 1'b0) c++;
                if (c == k + 1) begin hold_low = 1'b0; break; end
                @(negedge clk);
            end
        end
        while (exp_q.size() != 0) @(negedge clk);
        slave_low = 1'b0;
    endtask

    // Per-cycle comparison against the model, plus the watchdog.
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t  e;
            cycles++;
            if (exp_q.size() != 0) e = exp_q.pop_front();
            else begin
                e.scl = m_park ? 1'b1 : 1'b0; e.sda = m_sda; e.done = 1'b0;
                e.rdy = 1'b1; e.chk_rx = 1'b0; e.rx = 1'b0; e.tag = steady_tag;
            end
            checks++;
            if ({scl_oe, sda_oe, step_done, ready} !== {e.scl, e.sda, e.done, e.rdy}) begin
                errors++;
                $display("FAIL %s cycle %0d: scl/sda/done/rdy actual %b%b%b%b expected %b%b%b%b",
                         e.tag, cycles, scl_oe, sda_oe, step_done, ready,
                         e.scl, e.sda, e.done, e.rdy);
            end
            if (e.chk_rx) begin
                checks++;
                if (rx_bit !== e.rx) begin
                    errors++;
                    $display("FAIL R10 sampled bit actual %b expected %b", rx_bit, e.rx);
                end
            end
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual %0d cycles expected under 150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);               // R1 reset state
        steady_tag = "R11";
        issue(2'b01, 1'b0, 0, 1'b0);            // R11 STOP while idle ignored
        issue(2'b10, 1'b0, 0, 1'b0);            // R11 bit while idle ignored
        issue(2'b11, 1'b0, 0, 1'b0);            // R11 reserved ignored
        repeat (3) @(negedge clk);
        issue(2'b00, 1'b0, 0, 1'b0);            // R8 START from idle
        issue(2'b10, 1'b1, 0, 1'b0);            // R2 R3 R5 R6 floors
        issue(2'b10, 1'b0, 0, 1'b0);
        issue(2'b10, 1'b1, 0, 1'b1);            // R10 read, target pulls low
        issue(2'b10, 1'b1, 0, 1'b0);            // R10 read, released
        issue(2'b11, 1'b0, 0, 1'b0);            // R11 reserved while parked
        repeat (3) @(negedge clk);
        issue(2'b10, 1'b0, 5, 1'b0);            // R7 stretch
        std_hi = 16'd10; std_lo = 16'd20;
        issue(2'b10, 1'b1, 0, 1'b0);            // R2 R3 plain offsets
        fast_mode = 1'b1; hitag = "R4"; lotag = "R4";
        issue(2'b10, 1'b0, 0, 1'b0);            // R4 fast pair
        issue(2'b10, 1'b1, 0, 1'b0);
        hitag = "R2"; lotag = "R3";
        hold_cfg = {1'b0, 8'd9}; setup_cfg = 8'd1;
        issue(2'b10, 1'b0, 0, 1'b0);            // R5 hold disabled, R6 setup 1
        issue(2'b10, 1'b1, 0, 1'b0);
        setup_cfg = 8'd0;
        issue(2'b10, 1'b0, 0, 1'b0);            // R6 setup 0 floor
        hold_cfg = {1'b1, 8'd255}; setup_cfg = 8'd9;
        issue(2'b10, 1'b1, 0, 1'b0);            // R5 longest hold
        issue(2'b00, 1'b0, 0, 1'b0);            // R8 repeated START
        issue(2'b10, 1'b0, 0, 1'b0);
        issue(2'b01, 1'b0, 0, 1'b0);            // R9 STOP
        repeat (4) @(negedge clk);
        hold_cfg = {1'b1, 8'd2}; setup_cfg = 8'd1;
        issue(2'b00, 1'b0, 0, 1'b0);            // R8 START again
        issue(2'b01, 1'b0, 0, 1'b0);            // R9 STOP with no setup tail
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule